// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Copy Engine

This block copies a programmed number of bytes from a source address to a destination address over a generic memory master port. Software fills in a configuration word, a byte count and the two addresses through a small register port. It claims the channel, then sets the run bit. The engine then moves the data in power-of-two chunks. The chunk size comes from the smaller of a read-size and a write-size field. Any bytes left over after the last full chunk go out as one shorter transfer, so a count that is not a multiple of the chunk size is legal.

Each chunk is a read request, followed by its read response, followed by a write request that carries the same byte enables. The engine keeps its own cursor for source, destination and remaining count. The programmed registers therefore read back unchanged after a run. When the last write is accepted, the run bit drops, the claim bit stays set and a done flag is raised.

Top module: `mem_dma_top`

## Requirements
- R1: Register offsets are 0x00 control, 0x04 configuration (32 bits), 0x08 byte count, 0x10 destination and 0x18 source (64 bits each). Every register reads back exactly what was written, and it still does after a run.
- R2: Control word layout: bit 0 claim, bit 1 run, bit 30 done. While idle, a control write loads claim from bit 0. It starts a run only when the channel was already claimed and the written bits 1:0 are both 1. Starting sets run and clears done. A run request to an unclaimed channel does not start a run. Writing 0x0 releases the claim.
- R3: The read-size code sits in configuration bits 31:28 and the write-size code in bits 27:24. Each code is clamped to 6. The chunk size is 2 to the power of the smaller clamped code.
- R4: A run of N bytes with chunk size S issues floor(N/S) full chunks and then, if N mod S is nonzero, one chunk of N mod S bytes. That is exactly ceil(N/S) writes.
- R5: Data lane i of a request maps to address addr+i. Byte enables are a contiguous run from lane 0 whose length is the chunk length. After a run, destination bytes [dst, dst+N) equal the source bytes, and neighbouring bytes are untouched.
- R6: A request holds its fields until it is accepted. Each write follows the read response of the same chunk and uses the same byte enables. Only one read is outstanding at a time.
- R7: On completion, run clears, claim stays set and done sets, so control reads 0x40000001.
- R8: A byte count of zero completes with done set and no memory request.
- R9: While run is set, writes to every register, control included, are ignored. A write that lands in the completion cycle is also ignored.
- R10: After reset, all registers read zero and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Register write byte offset |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | 5 | Register read byte offset |
| reg_rd_data | output | 64 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 64 | Byte address of lane 0 |
| mem_req_be | output | 64 | Per-lane byte enables |
| mem_req_wdata | output | 512 | Write data, lane i in bits 8i+7:8i |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 512 | Read response data, lane i = byte at addr+i |

## Verification
A register write and the completion of a run can fall in the same cycle. The write sees the run bit still set and must be dropped. The bench provokes this during slow, stalled runs: it writes the byte count (and now and then the control word) every cycle, and it releases the write strobe in the same half-cycle in which it first sees done. The last write it issues therefore lands on the completion edge. The result is judged through the ports. The count must keep its programmed value and control must read 0x40000001. A write issued one cycle later must then take effect.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int XW = 64;

    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_CFG  = 5'h04;
    localparam logic [4:0] OFS_CNT  = 5'h08;
    localparam logic [4:0] OFS_DST  = 5'h10;
    localparam logic [4:0] OFS_SRC  = 5'h18;

    localparam int CTL_CLAIM = 0;
    localparam int CTL_RUN   = 1;
    localparam int CTL_DONE  = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_FIN
    } xfer_state_t;

    typedef struct packed {
        logic [31:0]   cfg;
        logic [XW-1:0] cnt;
        logic [XW-1:0] dst;
        logic [XW-1:0] src;
    } prog_t;

    typedef struct packed {
        logic [XW-1:0] src;
        logic [XW-1:0] dst;
        logic [XW-1:0] rem;
    } cursor_t;

    function automatic logic [3:0] clamp_code(input logic [3:0] code, input logic [3:0] maxl);
        return (code > maxl) ? maxl : code;
    endfunction

    function automatic logic [3:0] chunk_log(input logic [31:0] cfg, input logic [3:0] maxl);
        logic [3:0] r;
        logic [3:0] w;
        r = clamp_code(cfg[31:28], maxl);
        w = clamp_code(cfg[27:24], maxl);
        return (r < w) ? r : w;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [4:0]    wr_addr,
    input  logic [63:0]   wr_data,
    input  logic [4:0]    rd_addr,
    output logic [63:0]   rd_data,
    input  logic          fin,
    output logic          start,
    output prog_t         prog,
    output logic          claim_q,
    output logic          run_q,
    output logic          done_q
);

    logic [63:0] ctl_word;

    assign start = wr_en && (wr_addr == OFS_CTRL) && !run_q && claim_q
                   && wr_data[CTL_RUN] && wr_data[CTL_CLAIM];

    always_ff @(posedge clk) begin
        if (rst) begin
            prog    <= '0;
            claim_q <= 1'b0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (fin) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
            if (wr_en && !run_q) begin
                case (wr_addr)
                    OFS_CTRL: begin
                        claim_q <= wr_data[CTL_CLAIM];
                        if (start) begin
                            run_q  <= 1'b1;
                            done_q <= 1'b0;
                        end
                    end
                    OFS_CFG: prog.cfg <= wr_data[31:0];
                    OFS_CNT: prog.cnt <= wr_data;
                    OFS_DST: prog.dst <= wr_data;
                    OFS_SRC: prog.src <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ctl_word            = '0;
        ctl_word[CTL_CLAIM] = claim_q;
        ctl_word[CTL_RUN]   = run_q;
        ctl_word[CTL_DONE]  = done_q;
        case (rd_addr)
            OFS_CTRL: rd_data = ctl_word;
            OFS_CFG:  rd_data = {32'h0, prog.cfg};
            OFS_CNT:  rd_data = prog.cnt;
            OFS_DST:  rd_data = prog.dst;
            OFS_SRC:  rd_data = prog.src;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_chunk.sv
module dma_chunk
    import dma_pkg::*;
#(
    parameter int DATA_BYTES = 64
) (
    input  logic [XW-1:0]                rem,
    input  logic [3:0]                   lg,
    output logic [$clog2(DATA_BYTES):0]  len,
    output logic [DATA_BYTES-1:0]        be
);

    localparam int LW = $clog2(DATA_BYTES) + 1;

    logic [LW-1:0] full;

    assign full = LW'(1) << lg;
    assign len  = (rem >= XW'(full)) ? full : rem[LW-1:0];

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        assign be[g] = (len > LW'(g));
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DATA_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  prog_t                     prog,
    output logic                      fin,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_write,
    output logic [XW-1:0]             mem_req_addr,
    output logic [DATA_BYTES-1:0]     mem_req_be,
    output logic [8*DATA_BYTES-1:0]   mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [8*DATA_BYTES-1:0]   mem_rsp_rdata
);

    localparam int         LW   = $clog2(DATA_BYTES) + 1;
    localparam logic [3:0] MAXL = 4'($clog2(DATA_BYTES));

    xfer_state_t             st;
    cursor_t                 cur;
    logic [3:0]              lg;
    logic [8*DATA_BYTES-1:0] dbuf;
    logic [LW-1:0]           len;

    dma_chunk #(.DATA_BYTES(DATA_BYTES)) u_chunk (
        .rem (cur.rem),
        .lg  (lg),
        .len (len),
        .be  (mem_req_be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            lg   <= '0;
            dbuf <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cur.src <= prog.src;
                    cur.dst <= prog.dst;
                    cur.rem <= prog.cnt;
                    lg      <= chunk_log(prog.cfg, MAXL);
                    st      <= (prog.cnt == '0) ? ST_FIN : ST_RD;
                end
                ST_RD: if (mem_req_ready) st <= ST_RWAIT;
                ST_RWAIT: if (mem_rsp_valid) begin
                    dbuf <= mem_rsp_rdata;
                    st   <= ST_WR;
                end
                ST_WR: if (mem_req_ready) begin
                    cur.src <= cur.src + XW'(len);
                    cur.dst <= cur.dst + XW'(len);
                    cur.rem <= cur.rem - XW'(len);
                    st      <= (cur.rem == XW'(len)) ? ST_FIN : ST_RD;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign fin           = (st == ST_FIN);
    assign mem_req_valid = (st == ST_RD) || (st == ST_WR);
    assign mem_req_write = (st == ST_WR);
    assign mem_req_addr  = (st == ST_WR) ? cur.dst : cur.src;
    assign mem_req_wdata = dbuf;

endmodule

// File: rtl/mem_dma_top.sv
module mem_dma_top
    import dma_pkg::*;
#(
    parameter int DATA_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr_en,
    input  logic [4:0]                reg_wr_addr,
    input  logic [63:0]               reg_wr_data,
    input  logic [4:0]                reg_rd_addr,
    output logic [63:0]               reg_rd_data,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_write,
    output logic [63:0]               mem_req_addr,
    output logic [DATA_BYTES-1:0]     mem_req_be,
    output logic [8*DATA_BYTES-1:0]   mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [8*DATA_BYTES-1:0]   mem_rsp_rdata
);

    prog_t prog;
    logic  start;
    logic  fin;
    logic  claim_q;
    logic  run_q;
    logic  done_q;

    dma_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .fin     (fin),
        .start   (start),
        .prog    (prog),
        .claim_q (claim_q),
        .run_q   (run_q),
        .done_q  (done_q)
    );

    dma_engine #(.DATA_BYTES(DATA_BYTES)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .prog          (prog),
        .fin           (fin),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_be    (mem_req_be),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int DATA_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic [63:0]           req_addr,
    input logic [DATA_BYTES-1:0] req_be,
    input logic                  rsp_valid,
    input logic                  claim,
    input logic                  run,
    input logic                  done,
    input logic [63:0]           cnt_reg
);

    logic                  rd_pend;
    logic                  have_data;
    logic [DATA_BYTES-1:0] rd_be;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            have_data <= 1'b0;
            rd_be     <= '0;
        end else begin
            if (req_valid && req_ready && !req_write) begin
                rd_pend <= 1'b1;
                rd_be   <= req_be;
            end
            if (rsp_valid) begin
                rd_pend   <= 1'b0;
                have_data <= 1'b1;
            end
            if (req_valid && req_ready && req_write) have_data <= 1'b0;
        end
    end

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !req_valid);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_write)
                                    && $stable(req_addr) && $stable(req_be));

    // R5
    be_contig_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_be != '0) && ((req_be & (req_be + 1'b1)) == '0));

    // R6
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |-> have_data && !rd_pend && (req_be == rd_be));

    // R6
    one_rd_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write |-> !rd_pend && !have_data);

    // R7
    finish_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> done && claim);

    // R9
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) |-> $stable(cnt_reg));

endmodule

bind mem_dma_top dma_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_write (mem_req_write),
    .req_addr  (mem_req_addr),
    .req_be    (mem_req_be),
    .rsp_valid (mem_rsp_valid),
    .claim     (claim_q),
    .run       (run_q),
    .done      (done_q),
    .cnt_reg   (prog.cnt)
);

// File: tb/sim_mem_dma_top.sv
module sim_mem_dma_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 64;
    localparam int MEMSZ      = 1024;
    localparam int TIMEOUT    = 190000;
    localparam logic [63:0] SRC_BASE = 64'h040;
    localparam logic [63:0] DST_BASE = 64'h200;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr_en = 1'b0;
    logic [4:0]      reg_wr_addr = '0;
    logic [63:0]     reg_wr_data = '0;
    logic [4:0]      reg_rd_addr = '0;
    logic [63:0]     reg_rd_data;
    logic            mem_req_valid;
    logic            mem_req_ready;
    logic            mem_req_write;
    logic [63:0]     mem_req_addr;
    logic [NB-1:0]   mem_req_be;
    logic [8*NB-1:0] mem_req_wdata;
    logic            mem_rsp_valid;
    logic [8*NB-1:0] mem_rsp_rdata;

    logic [7:0] mem [MEMSZ];
    logic       tb_init = 1'b0;
    int         tb_seed = 0;
    logic       stall = 1'b0;
    int         cyc = 0;
    int         wr_n = 0;
    int         rd_n = 0;
    int         total = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_dma_top u0 (
        .clk           (clk),
        .rst           (rst),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_addr   (reg_wr_addr),
        .reg_wr_data   (reg_wr_data),
        .reg_rd_addr   (reg_rd_addr),
        .reg_rd_data   (reg_rd_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_be    (mem_req_be),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'(a * 7 + s * 13 + (a >> 3) + 1);
    endfunction

    assign mem_req_ready = !stall || (cyc % 3 == 2);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tb_init) begin
            for (int a = 0; a < MEMSZ; a++) mem[a] <= pat(a, tb_seed);
            wr_n          <= 0;
            rd_n          <= 0;
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wr_n <= wr_n + 1;
                    for (int i = 0; i < NB; i++)
                        if (mem_req_be[i])
                            mem[(int'(mem_req_addr[9:0]) + i) % MEMSZ] <= mem_req_wdata[i*8 +: 8];
                end else begin
                    rd_n          <= rd_n + 1;
                    mem_rsp_valid <= 1'b1;
                    for (int i = 0; i < NB; i++)
                        mem_rsp_rdata[i*8 +: 8] <= mem[(int'(mem_req_addr[9:0]) + i) % MEMSZ];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic wait_done(output logic [63:0] ctl);
        ctl = '0;
        for (int k = 0; k < 4000; k++) begin
            reg_rd(5'h00, ctl);
            if (ctl[30]) break;
        end
    endtask

    task automatic init_mem(input int seed);
        @(negedge clk);
        tb_seed = seed;
        tb_init = 1'b1;
        @(negedge clk);
        tb_init = 1'b0;
    endtask

    task automatic check_mem(input string tag, input int src, input int dst, input int n, input int seed);
        int bad;
        logic [7:0] e;
        logic [7:0] firsta;
        logic [7:0] firste;
        bad = 0;
        firsta = '0;
        firste = '0;
        for (int a = dst - 4; a < dst + n + 4; a++) begin
            e = (a >= dst && a < dst + n) ? pat(src + (a - dst), seed) : pat(a, seed);
            if (mem[a] !== e) begin
                if (bad == 0) begin firsta = mem[a]; firste = e; end
                bad++;
            end
        end
        chk($sformatf("%s mismatching bytes (first act %h exp %h)", tag, firsta, firste), 64'(bad), 64'd0);
    endtask

    task automatic xfer(input int rdc, input int wrc, input int n, input int so, input int dof,
                        input logic stl, input int seed);
        int lg;
        int sz;
        int exp_wr;
        int src;
        int dst;
        logic [63:0] v;
        lg     = (rdc > 6 ? 6 : rdc) < (wrc > 6 ? 6 : wrc) ? (rdc > 6 ? 6 : rdc) : (wrc > 6 ? 6 : wrc);
        sz     = 1 << lg;
        exp_wr = n / sz + ((n % sz) != 0 ? 1 : 0);
        src    = int'(SRC_BASE) + so;
        dst    = int'(DST_BASE) + dof;
        stall  = stl;
        init_mem(seed);
        reg_wr(5'h04, {32'h0, 4'(rdc), 4'(wrc), 24'h0});
        reg_wr(5'h08, 64'(n));
        reg_wr(5'h10, 64'(dst));
        reg_wr(5'h18, 64'(src));
        reg_wr(5'h00, 64'h1);
        reg_wr(5'h00, 64'h3);
        wait_done(v);
        // R7
        chk($sformatf("R7 control after run rd=%0d wr=%0d n=%0d", rdc, wrc, n), v, 64'h4000_0001);
        // R4 / R3 / R8
        chk($sformatf("R4 R3 R8 write count rd=%0d wr=%0d n=%0d", rdc, wrc, n), 64'(wr_n), 64'(exp_wr));
        // R6
        chk($sformatf("R6 reads equal writes n=%0d", n), 64'(rd_n), 64'(exp_wr));
        // R5
        check_mem($sformatf("R5 copy rd=%0d wr=%0d n=%0d", rdc, wrc, n), src, dst, n, seed);
        // R1
        reg_rd(5'h08, v);
        chk("R1 count readback after run", v, 64'(n));
        reg_rd(5'h10, v);
        chk("R1 destination readback after run", v, 64'(dst));
    endtask

    initial begin : watchdog
        repeat (TIMEOUT) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R7 watchdog actual=still running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [63:0] v;
        int seed;
        seed = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        reg_rd(5'h00, v); chk("R10 control after reset", v, 64'h0);
        reg_rd(5'h04, v); chk("R10 config after reset", v, 64'h0);
        reg_rd(5'h08, v); chk("R10 count after reset", v, 64'h0);
        reg_rd(5'h10, v); chk("R10 destination after reset", v, 64'h0);
        reg_rd(5'h18, v); chk("R10 source after reset", v, 64'h0);

        // R1 register readback
        reg_wr(5'h04, 64'hFFFF_FFFF_A5C3_0F01);
        reg_rd(5'h04, v); chk("R1 config 32-bit readback", v, 64'h0000_0000_A5C3_0F01);
        reg_wr(5'h18, 64'h0123_4567_89AB_CDEF);
        reg_rd(5'h18, v); chk("R1 source readback", v, 64'h0123_4567_89AB_CDEF);

        // R2 claim rules
        init_mem(seed);
        reg_wr(5'h08, 64'd4);
        reg_wr(5'h00, 64'h2);
        repeat (4) @(negedge clk);
        reg_rd(5'h00, v); chk("R2 run without claim ignored", v, 64'h0);
        chk("R2 no request without claim", 64'(rd_n), 64'd0);
        reg_wr(5'h00, 64'h3);
        repeat (4) @(negedge clk);
        reg_rd(5'h00, v); chk("R2 unclaimed 0x3 only claims", v, 64'h1);
        chk("R2 no request on unclaimed 0x3", 64'(rd_n), 64'd0);
        reg_wr(5'h00, 64'h0);
        reg_rd(5'h00, v); chk("R2 release claim", v, 64'h0);

        // main sweep: R3 R4 R5 R6 R7 R8
        for (int c = 0; c <= 6; c++) begin
            for (int n = 0; n <= 36; n++) begin
                seed++;
                xfer(c, c, n, n % 5, (n * 3) % 7, logic'((n + c) % 2), seed);
            end
        end
        // R3 mixed and clamped size codes
        xfer(2, 5, 13, 1, 2, 1'b0, 401);
        xfer(5, 2, 13, 3, 0, 1'b1, 402);
        xfer(9, 7, 130, 2, 5, 1'b0, 403);
        xfer(15, 3, 29, 0, 1, 1'b1, 404);
        xfer(6, 6, 63, 4, 6, 1'b1, 405);
        xfer(6, 6, 64, 0, 0, 1'b0, 406);
        xfer(6, 15, 65, 7, 3, 1'b0, 407);
        xfer(1, 1, 3, 0, 0, 1'b0, 408);

        // R2 start clears done; R9 writes during run and at completion ignored
        init_mem(500);
        stall = 1'b1;
        reg_wr(5'h04, 64'h0000_0000_0000_0000);
        reg_wr(5'h08, 64'd24);
        reg_wr(5'h10, DST_BASE);
        reg_wr(5'h18, SRC_BASE);
        reg_wr(5'h00, 64'h3);
        reg_rd(5'h00, v); chk("R2 run set and done cleared at start", v, 64'h3);
        reg_rd_addr = 5'h00;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            reg_wr_en   = 1'b1;
            reg_wr_addr = (k % 4 == 3) ? 5'h00 : 5'h08;
            reg_wr_data = (k % 4 == 3) ? 64'h0 : 64'(1000 + k);
            reg_rd_addr = 5'h00;
            #1;
            if (reg_rd_data[30]) begin
                reg_wr_en = 1'b0;
                break;
            end
        end
        reg_wr_en = 1'b0;
        reg_rd(5'h00, v); chk("R9 control writes during run ignored", v, 64'h4000_0001);
        reg_rd(5'h08, v); chk("R9 count writes during run and at completion ignored", v, 64'd24);
        check_mem("R9 R5 copy under register traffic", int'(SRC_BASE), int'(DST_BASE), 24, 500);
        reg_wr(5'h08, 64'h55);
        reg_rd(5'h08, v); chk("R9 write after completion takes effect", v, 64'h55);

        // R2 release after done keeps done flag
        reg_wr(5'h00, 64'h0);
        reg_rd(5'h00, v); chk("R2 release after run", v, 64'h4000_0000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule